// File: doc/BRIEF.md
# One-Hot Select Configuration Address Decoder

This block turns CPU loads and stores into configuration requests for a conventional PCI configuration port. It offers two ways in. The first is a 4 MB memory window where each device has its own address bit. The block scans window-offset bits 11 upward and takes the first set bit as the device number. The 11 low offset bits are passed on unchanged as function and register number. The second way is a classic pair of 32-bit registers in the I/O space: an index register that holds the target address and a data register that carries the transfer.

The CPU side uses a simple valid/ready request with address, byte size and write data. Data is little-endian. Byte lanes are chosen from the two low address bits. Each accepted request that targets configuration space sends out exactly one single-cycle downstream request. The CPU is then held until the port acknowledges. If the port never acknowledges, the access is closed after a fixed number of cycles. Accesses that hit neither path complete at once with no side effect.

Top module: `cfg_onehot_decoder`

## Requirements
- R1: An access whose address lies in [CFG_BASE, CFG_BASE+4 MB) issues one downstream request. An access that hits neither the window nor the I/O registers issues none, returns all-ones read data and completes one cycle after acceptance.
- R2: In the window, the device number in cfg_addr[15:11] is i, where window-offset bit 11+i is the lowest set bit among offset bits 11 to 21.
- R3: In the window, when offset bits 11 to 21 are all zero, the device number is 11.
- R4: In the window, cfg_addr[10:0] equals the window-offset bits 10:0.
- R5: Sizes are 1, 2 and 4 bytes, little-endian:
  - cfg_wdata is the write data shifted left by 8×addr[1:0].
  - cfg_be is 0001, 0011 or 1111 shifted left by addr[1:0].
  - Read data is the acknowledged lanes shifted right by 8×addr[1:0], with the bytes above the size cleared.
- R6: An aligned 4-byte write to IO_BASE+0xCF8 stores the data with bits 30:24 and 1:0 cleared. An aligned 4-byte read there returns the stored value.
- R7: When index bit 31 is set, an access to IO_BASE+0xCFC..0xCFF issues a request with cfg_addr = {index[15:2], addr[1:0]}. When bit 31 is clear, no request is issued, reads return all ones, and writes are dropped.
- R8: An access with a size other than 1, 2 or 4, or one not aligned to its size, issues no request and reads all ones.
- R9: cfg_valid is high for exactly one cycle per request, in the cycle after the CPU request is accepted.
- R10: cpu_ready stays low while a request waits. It pulses for one cycle, in the cycle after cfg_ack is sampled.
- R11: A request that gets no cfg_ack within TIMEOUT cycles completes with read data all ones in the accessed bytes.
- R12: After reset, cfg_valid and cpu_ready are low and the index register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request present; held until cpu_ready |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 3 | Access size in bytes (1, 2, 4) |
| cpu_wdata | input | 32 | Write data, right-justified |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cfg_valid | output | 1 | One-cycle downstream request |
| cfg_write | output | 1 | Downstream write flag |
| cfg_addr | output | 16 | Device[15:11], function/register[10:0] |
| cfg_size | output | 3 | Downstream byte size |
| cfg_wdata | output | 32 | Lane-placed write data |
| cfg_be | output | 4 | Byte enables |
| cfg_ack | input | 1 | Downstream acknowledge |
| cfg_rdata | input | 32 | Lane-placed read data, valid with cfg_ack |

## Verification
The bench covers several select patterns:
- Offsets with several select bits set at once. A decoder that picked the highest set bit, or scanned in the wrong direction, would report the wrong device number.
- An offset with no select bit set. A wrong fallback would produce index 0 instead of 11.
- Only the top select bit set.

It checks lane placement on odd byte addresses. A shifted-by-bytes error would corrupt cfg_be or the returned halfword. It probes the addresses just below and just above the window, and a misaligned word, none of which may produce a request. On the indirect path it checks the masking of the index register and that nothing is issued while the enable bit is clear. It also checks that a silent port yields all-ones after the timeout rather than a hang, and that ready comes exactly one cycle after a delayed acknowledge.

// File: rtl/cfg_onehot_decoder.sv
module cfg_onehot_decoder #(
  parameter logic [31:0] CFG_BASE = 32'h8080_0000,
  parameter logic [31:0] IO_BASE  = 32'h8000_0000,
  parameter int          SEL_BITS = 11,
  parameter int          TIMEOUT  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_valid,
  input  logic        cpu_write,
  input  logic [31:0] cpu_addr,
  input  logic [2:0]  cpu_size,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ready,
  output logic [31:0] cpu_rdata,
  output logic        cfg_valid,
  output logic        cfg_write,
  output logic [15:0] cfg_addr,
  output logic [2:0]  cfg_size,
  output logic [31:0] cfg_wdata,
  output logic [3:0]  cfg_be,
  input  logic        cfg_ack,
  input  logic [31:0] cfg_rdata
);
  localparam int          SEL_LSB  = 11;
  localparam int          WIN_BITS = SEL_LSB + SEL_BITS;
  localparam int          CNT_W    = $clog2(TIMEOUT + 1);
  localparam logic [31:0] IDX_ADDR = IO_BASE + 32'hCF8;
  localparam logic [31:0] DAT_ADDR = IO_BASE + 32'hCFC;
  localparam logic [31:0] IDX_KEEP = 32'h80FF_FFFC;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} st_t;

  function automatic logic [31:0] fill(input logic [2:0] s);
    case (s)
      3'd1:    fill = 32'h0000_00FF;
      3'd2:    fill = 32'h0000_FFFF;
      default: fill = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] lanes(input logic [2:0] s);
    case (s)
      3'd1:    lanes = 4'b0001;
      3'd2:    lanes = 4'b0011;
      default: lanes = 4'b1111;
    endcase
  endfunction

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      idx_q, rdata_q;
  logic [1:0]       lo_q;
  logic [2:0]       sz_q;
  logic             cfg_valid_q, cfg_write_q;
  logic [15:0]      cfg_addr_q;
  logic [2:0]       cfg_size_q;
  logic [31:0]      cfg_wdata_q;
  logic [3:0]       cfg_be_q;
  logic [4:0]       dev;
  logic             found;

  wire in_win  = (cpu_addr >> WIN_BITS) == (CFG_BASE >> WIN_BITS);
  wire in_idx  = cpu_addr[31:2] == IDX_ADDR[31:2];
  wire in_dat  = cpu_addr[31:2] == DAT_ADDR[31:2];
  wire size_ok = (cpu_size == 3'd1) ||
                 (cpu_size == 3'd2 && !cpu_addr[0]) ||
                 (cpu_size == 3'd4 && cpu_addr[1:0] == 2'b00);

  always_comb begin
    dev   = 5'(SEL_BITS);
    found = 1'b0;
    for (int i = 0; i < SEL_BITS; i++) begin
      if (!found && cpu_addr[SEL_LSB + i]) begin
        dev   = 5'(i);
        found = 1'b1;
      end
    end
  end

  wire [15:0] win_addr = {dev, cpu_addr[10:0]};
  wire [15:0] ind_addr = {idx_q[15:2], cpu_addr[1:0]};
  wire        go_win   = size_ok && in_win;
  wire        go_ind   = size_ok && !in_win && in_dat && idx_q[31];
  wire        idx_hit  = in_idx && cpu_size == 3'd4 && cpu_addr[1:0] == 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      idx_q       <= '0;
      rdata_q     <= '0;
      lo_q        <= '0;
      sz_q        <= '0;
      cfg_valid_q <= 1'b0;
      cfg_write_q <= 1'b0;
      cfg_addr_q  <= '0;
      cfg_size_q  <= '0;
      cfg_wdata_q <= '0;
      cfg_be_q    <= '0;
    end else begin
      cfg_valid_q <= 1'b0;
      case (state)
        S_IDLE: if (cpu_valid) begin
          lo_q <= cpu_addr[1:0];
          sz_q <= cpu_size;
          cnt  <= '0;
          if (go_win || go_ind) begin
            cfg_valid_q <= 1'b1;
            cfg_write_q <= cpu_write;
            cfg_addr_q  <= go_win ? win_addr : ind_addr;
            cfg_size_q  <= cpu_size;
            cfg_wdata_q <= cpu_wdata << {cpu_addr[1:0], 3'b000};
            cfg_be_q    <= lanes(cpu_size) << cpu_addr[1:0];
            state       <= S_WAIT;
          end else begin
            state <= S_DONE;
            if (size_ok && idx_hit) begin
              rdata_q <= idx_q;
              if (cpu_write) idx_q <= cpu_wdata & IDX_KEEP;
            end else begin
              rdata_q <= fill(cpu_size);
            end
          end
        end
        S_WAIT: begin
          if (cfg_ack) begin
            rdata_q <= (cfg_rdata >> {lo_q, 3'b000}) & fill(sz_q);
            state   <= S_DONE;
          end else if (cnt == CNT_W'(TIMEOUT - 1)) begin
            rdata_q <= fill(sz_q);
            state   <= S_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cpu_ready = state == S_DONE;
  assign cpu_rdata = rdata_q;
  assign cfg_valid = cfg_valid_q;
  assign cfg_write = cfg_write_q;
  assign cfg_addr  = cfg_addr_q;
  assign cfg_size  = cfg_size_q;
  assign cfg_wdata = cfg_wdata_q;
  assign cfg_be    = cfg_be_q;
endmodule

module cfg_onehot_decoder_chk #(
  parameter logic [31:0] CFG_BASE = 32'h8080_0000,
  parameter int          WIN_BITS = 22
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_valid,
  input logic [31:0] cpu_addr,
  input logic        cpu_ready,
  input logic        cfg_valid,
  input logic [15:0] cfg_addr,
  input logic [3:0]  cfg_be
);
  a_r9_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> !cfg_valid);
  a_r9_req_from_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> $past(cpu_valid));
  a_r10_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  a_r10_no_ready_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> !cpu_ready);
  a_r5_be_count: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2 ||
                   $countones(cfg_be) == 4));
  a_r4_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && (($past(cpu_addr) >> WIN_BITS) == (CFG_BASE >> WIN_BITS)))
      |-> cfg_addr[10:0] == $past(cpu_addr[10:0]));
endmodule

bind cfg_onehot_decoder cfg_onehot_decoder_chk #(
  .CFG_BASE(CFG_BASE), .WIN_BITS(WIN_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
  .cpu_ready(cpu_ready), .cfg_valid(cfg_valid), .cfg_addr(cfg_addr),
  .cfg_be(cfg_be)
);

// File: tb/tb_cfg_onehot_decoder.sv
module tb_cfg_onehot_decoder;
  localparam int TMO = 16;
  localparam logic [31:0] WB = 32'h8080_0000;
  localparam logic [31:0] IB = 32'h8000_0000;

  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_write = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [2:0] cpu_size = 0;
  logic cpu_ready, cfg_valid, cfg_write;
  logic [31:0] cpu_rdata, cfg_wdata;
  logic [15:0] cfg_addr;
  logic [2:0] cfg_size;
  logic [3:0] cfg_be;
  logic cfg_ack = 0;
  logic [31:0] cfg_rdata = 0;

  int total = 0, bad = 0;
  int reqs, lat;
  logic [15:0] g_addr;
  logic [31:0] g_wdata, g_rdata;
  logic [3:0] g_be;

  always #5 clk = ~clk;

  cfg_onehot_decoder #(.TIMEOUT(TMO)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [31:0] a, input logic [2:0] sz,
                     input logic [31:0] wd, input int dly, input logic [31:0] lanes);
    int seen;
    seen = -1; reqs = 0; lat = -1; g_addr = 'x; g_wdata = 'x; g_be = 'x; g_rdata = 'x;
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    for (int c = 0; c < TMO + 20; c++) begin
      @(negedge clk);
      cfg_ack = 0;
      if (cpu_ready) begin
        g_rdata = cpu_rdata;
        lat = (seen >= 0) ? c - seen : c;
        break;
      end
      if (cfg_valid) begin
        reqs++; seen = c; g_addr = cfg_addr; g_wdata = cfg_wdata; g_be = cfg_be;
      end
      if (seen >= 0 && dly >= 0 && c == seen + dly) begin
        cfg_ack = 1; cfg_rdata = lanes;
      end
    end
    cpu_valid = 0; cfg_ack = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 cfg_valid", 32'(cfg_valid), 0);
    chk("R12 cpu_ready", 32'(cpu_ready), 0);
    acc(0, IB + 32'hCF8, 4, 0, -1, 0);
    chk("R12 index", g_rdata, 0);
  endtask

  task automatic t_window;
    acc(1, WB + (32'h1 << 13) + 32'h123, 1, 32'hAB, 0, 0);
    chk("R1 one req", reqs, 1);
    chk("R2 dev2 addr", 32'(g_addr), 32'h1123);
    chk("R5 byte lane", g_wdata, 32'hAB00_0000);
    chk("R5 byte be", 32'(g_be), 32'h8);
    acc(0, WB + (32'h1 << 20) + (32'h1 << 14) + 32'h40, 4, 0, 0, 32'h1122_3344);
    chk("R2 lowest bit wins", 32'(g_addr), 32'h1840);
    chk("R5 word read", g_rdata, 32'h1122_3344);
    acc(0, WB + 32'h7FC, 2, 0, 0, 32'hAABB_CCDD);
    chk("R3 no select bit", 32'(g_addr), 32'h5FFC);
    chk("R5 half read", g_rdata, 32'h0000_CCDD);
    acc(1, WB + (32'h1 << 21) + 32'h2, 2, 32'hBEEF, 0, 0);
    chk("R2 top bit", 32'(g_addr), 32'h5002);
    chk("R4 low pass", 32'(g_addr[10:0]), 32'h002);
    chk("R5 half lane", g_wdata, 32'hBEEF_0000);
    chk("R5 half be", 32'(g_be), 32'hC);
  endtask

  task automatic t_outside;
    acc(0, WB - 32'h4, 4, 0, 0, 0);
    chk("R1 below window", reqs, 0);
    chk("R1 below rdata", g_rdata, 32'hFFFF_FFFF);
    chk("R1 local latency", lat, 0);
    acc(0, WB + 32'h0040_0000, 4, 0, 0, 0);
    chk("R1 above window", reqs, 0);
  endtask

  task automatic t_misalign;
    acc(0, WB + 32'h801, 4, 0, 0, 0);
    chk("R8 misaligned", reqs, 0);
    chk("R8 rdata", g_rdata, 32'hFFFF_FFFF);
    acc(0, WB + 32'h800, 3, 0, 0, 0);
    chk("R8 bad size", reqs, 0);
  endtask

  task automatic t_indirect;
    acc(1, IB + 32'hCF8, 4, 32'hFFFF_FFFF, -1, 0);
    acc(0, IB + 32'hCF8, 4, 0, -1, 0);
    chk("R6 index mask", g_rdata, 32'h80FF_FFFC);
    acc(1, IB + 32'hCF8, 4, 32'h8000_1A04, -1, 0);
    acc(0, IB + 32'hCFE, 2, 0, 0, 32'h5566_7788);
    chk("R7 one req", reqs, 1);
    chk("R7 addr", 32'(g_addr), 32'h1A06);
    chk("R7 be", 32'(g_be), 32'hC);
    chk("R7 rdata", g_rdata, 32'h0000_5566);
    acc(1, IB + 32'hCF8, 4, 32'h0000_1A04, -1, 0);
    acc(0, IB + 32'hCFC, 4, 0, 0, 32'h1234_5678);
    chk("R7 disabled no req", reqs, 0);
    chk("R7 disabled rdata", g_rdata, 32'hFFFF_FFFF);
    acc(1, IB + 32'hCFD, 1, 32'h5A, 0, 0);
    chk("R7 disabled write dropped", reqs, 0);
  endtask

  task automatic t_timing;
    acc(0, WB + 32'h803, 1, 0, 3, 32'h7700_0000);
    chk("R10 ready after ack", lat, 4);
    chk("R9 single req", reqs, 1);
    chk("R2 dev0", 32'(g_addr), 32'h0003);
    chk("R5 top byte", g_rdata, 32'h77);
    acc(0, WB + 32'h803, 1, 0, -1, 0);
    chk("R11 timeout rdata", g_rdata, 32'hFF);
    chk("R11 one req", reqs, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_window;
    t_outside;
    t_misalign;
    t_indirect;
    t_timing;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule